// File: doc/BRIEF.md
# Victim Line Buffer

This block is a small fully associative store of cache lines placed beside a direct-mapped primary cache, on the path that refills that cache. It keeps only lines that the primary cache has pushed out. After the primary cache misses, the cache probes this buffer with the block address it needs, together with the line currently sitting in the primary slot, which is about to be displaced. The buffer compares the address against every entry in parallel.

When an entry matches, the buffer returns that line and stores the displaced primary line into the entry the returned line vacated, so the two lines trade places. When no entry matches, the buffer sends a request to the next memory level and waits for the data. It then hands the returned line to the primary cache as a fill and stores the displaced line, if it was valid. New lines enter at a round-robin pointer, so the oldest insertion is overwritten first.

The probe port and the memory request port are valid/ready streams. A probe is taken on a clock edge where `probe_valid` and `probe_ready` are both high. `probe_ready` stays low while a miss is outstanding. A memory request, once raised, holds its valid and address until `mem_req_ready` is seen high. The memory response is taken when `mem_rsp_valid` and `mem_rsp_ready` are both high. The probe response and the fill are single-cycle pulses with no back-pressure, because the primary cache is stalled waiting for them.

Top module: `vcb_victim_buffer`

## Requirements
- R1: After reset every entry is invalid, `probe_ready` is high and `rsp_valid`, `mem_req_valid` and `fill_valid` are low; a probe after reset misses whatever was stored before.
- R2: A probe hits when any valid entry holds a block address equal to `probe_addr`, whichever entry it is; at most one entry matches.
- R3: One cycle after a probe is accepted, `rsp_valid` is high for one cycle with `rsp_hit`, and on a hit `rsp_line` carries the stored line.
- R4: On a hit, the same edge writes `evict_valid`, `evict_addr` and `evict_line` into the matching entry, so a later probe of the displaced address hits; if `evict_valid` was low the entry becomes invalid. No memory request is made.
- R5: On a miss, `mem_req_valid` rises in the same cycle as the miss response, carrying the probed block address, and stays high with a stable address until accepted by `mem_req_ready`.
- R6: `probe_ready` is low from the cycle after a miss is accepted until the cycle after the memory response is accepted.
- R7: `mem_rsp_ready` is high only while waiting for data; one cycle after a response is accepted, `fill_valid` pulses with `fill_line` equal to `mem_rsp_line`.
- R8: When the memory response is accepted, the displaced line captured with the missing probe is inserted if its valid bit was set; an invalid displaced line inserts nothing.
- R9: Insertions go to the entry at a round-robin pointer that starts at entry 0 after reset and advances after each insertion, so with all entries full the earliest inserted line is replaced.
- R10: A swap on a hit does not move the replacement pointer: the swapped-in line keeps the age of the entry it took.
- R11: When two addresses that map to the same primary slot are accessed alternately, every access after the first two fills is served by the primary cache or by the buffer, with no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| probe_valid | input | 1 | Probe request valid |
| probe_ready | output | 1 | Buffer can take a probe |
| probe_addr | input | ADDR_W | Block address the primary cache missed on |
| evict_valid | input | 1 | The primary slot holds a valid line that the access displaces |
| evict_addr | input | ADDR_W | Block address of the displaced primary line |
| evict_line | input | LINE_W | Data of the displaced primary line |
| rsp_valid | output | 1 | Probe result pulse |
| rsp_hit | output | 1 | Probe found the line in the buffer |
| rsp_line | output | LINE_W | Line returned on a hit |
| mem_req_valid | output | 1 | Request to the next memory level |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Block address requested from memory |
| mem_rsp_valid | input | 1 | Memory returns data |
| mem_rsp_ready | output | 1 | Buffer is waiting for memory data |
| mem_rsp_line | input | LINE_W | Line returned by memory |
| fill_valid | output | 1 | Fill pulse toward the primary cache |
| fill_line | output | LINE_W | Line to write into the primary slot |

## Verification
The bench targets the replacement order. It fills all four entries through a run of conflicting misses, then probes the line that should have been evicted first and expects a miss. A pointer that advanced on swaps, or that started elsewhere, would evict a different line, and one of the following probes would miss or hit wrongly. It also swaps in a line and expects that line to be the next one overwritten; a design that reordered entries on a swap would keep it. Other tests cover swaps where the displaced line was invalid, which must empty the entry; a design that kept the stale tag would report a false hit. They also cover memory back-pressure, where a design that dropped the request or changed its address before acceptance is caught, and a reset in mid-use, after which a design that did not clear its valid bits would hit.

// File: rtl/vcb_pkg.sv
package vcb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } vcb_state_e;
endpackage

// File: rtl/vcb_match.sv
// Parallel tag comparison across all entries.
module vcb_match #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 28,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ADDR_W-1:0]  tags [ENTRIES],
  input  logic [ADDR_W-1:0]  key,
  output logic [ENTRIES-1:0] match_vec,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = valid_vec[g] && (tags[g] == key);
  end

  assign hit = |match_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) hit_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/vcb_store.sv
// Entry storage: valid bits under reset, tags and lines without.
module vcb_store #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 28,
  parameter int LINE_W  = 128,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic               wr_valid,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [LINE_W-1:0]  wr_line,
  output logic [ENTRIES-1:0] valid_vec,
  output logic [ADDR_W-1:0]  tags  [ENTRIES],
  output logic [LINE_W-1:0]  lines [ENTRIES]
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n)   valid_vec[g] <= 1'b0;
      else if (sel) valid_vec[g] <= wr_valid;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tags[g]  <= wr_addr;
        lines[g] <= wr_line;
      end
    end
  end
endmodule

// File: rtl/vcb_repl.sv
// Round-robin insertion pointer giving first-in first-out replacement.
module vcb_repl #(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/vcb_victim_buffer.sv
module vcb_victim_buffer
  import vcb_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 28,
  parameter int LINE_W  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              probe_valid,
  output logic              probe_ready,
  input  logic [ADDR_W-1:0] probe_addr,
  input  logic              evict_valid,
  input  logic [ADDR_W-1:0] evict_addr,
  input  logic [LINE_W-1:0] evict_line,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [LINE_W-1:0] rsp_line,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [LINE_W-1:0] mem_rsp_line,
  output logic              fill_valid,
  output logic [LINE_W-1:0] fill_line
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  vcb_state_e state;

  logic [ENTRIES-1:0] valid_vec;
  logic [ADDR_W-1:0]  tags  [ENTRIES];
  logic [LINE_W-1:0]  lines [ENTRIES];
  logic [ENTRIES-1:0] match_vec;
  logic               hit;
  logic [IDX_W-1:0]   hit_idx;
  logic [IDX_W-1:0]   ptr;

  logic               accept, swap, mem_take, insert;
  logic               wr_en, wr_valid;
  logic [IDX_W-1:0]   wr_idx;
  logic [ADDR_W-1:0]  wr_addr;
  logic [LINE_W-1:0]  wr_line;

  // Held copy of the missing request and the line it displaces
  logic [ADDR_W-1:0]  pend_addr;
  logic               pend_ev_valid;
  logic [ADDR_W-1:0]  pend_ev_addr;
  logic [LINE_W-1:0]  pend_ev_line;

  assign probe_ready   = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_REQ);
  assign mem_req_addr  = pend_addr;
  assign mem_rsp_ready = (state == ST_WAIT);

  assign accept   = probe_valid && probe_ready;
  assign swap     = accept && hit;
  assign mem_take = mem_rsp_valid && mem_rsp_ready;
  assign insert   = mem_take && pend_ev_valid;

  vcb_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_match (
    .valid_vec (valid_vec),
    .tags      (tags),
    .key       (probe_addr),
    .match_vec (match_vec),
    .hit       (hit),
    .hit_idx   (hit_idx)
  );

  // Swap and insert never coincide: probes are blocked while a miss is open
  always_comb begin
    wr_en    = swap || insert;
    wr_idx   = swap ? hit_idx : ptr;
    wr_valid = swap ? evict_valid : 1'b1;
    wr_addr  = swap ? evict_addr  : pend_ev_addr;
    wr_line  = swap ? evict_line  : pend_ev_line;
  end

  vcb_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_line   (wr_line),
    .valid_vec (valid_vec),
    .tags      (tags),
    .lines     (lines)
  );

  vcb_repl #(.ENTRIES(ENTRIES)) u_repl (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (insert),
    .ptr   (ptr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      fill_valid <= 1'b0;
    end else begin
      rsp_valid  <= accept;
      rsp_hit    <= swap;
      fill_valid <= mem_take;
      unique case (state)
        ST_IDLE: if (accept && !hit)  state <= ST_REQ;
        ST_REQ:  if (mem_req_ready)   state <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid)   state <= ST_IDLE;
        default:                      state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (swap) rsp_line <= lines[hit_idx];
    if (mem_take) fill_line <= mem_rsp_line;
    if (accept && !hit) begin
      pend_addr     <= probe_addr;
      pend_ev_valid <= evict_valid;
      pend_ev_addr  <= evict_addr;
      pend_ev_line  <= evict_line;
    end
  end
endmodule

// File: rtl/vcb_victim_buffer_chk.sv
module vcb_victim_buffer_chk #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 28
) (
  input logic               clk,
  input logic               rst_n,
  input logic               probe_valid,
  input logic               probe_ready,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               mem_req_valid,
  input logic               mem_req_ready,
  input logic [ADDR_W-1:0]  mem_req_addr,
  input logic               mem_rsp_valid,
  input logic               mem_rsp_ready,
  input logic               fill_valid,
  input logic [ENTRIES-1:0] match_vec
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> !rsp_valid && !mem_req_valid && !fill_valid && probe_ready);

  assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  assert_rsp_follows_probe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    probe_valid && probe_ready |=> rsp_valid);

  assert_hit_no_mem_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> rsp_valid && !rsp_hit);

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_busy_blocks_probe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || mem_rsp_ready) |-> !probe_ready);

  assert_fill_after_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> $past(mem_rsp_valid && mem_rsp_ready));
endmodule

bind vcb_victim_buffer vcb_victim_buffer_chk #(
  .ENTRIES (ENTRIES),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .probe_valid   (probe_valid),
  .probe_ready   (probe_ready),
  .rsp_valid     (rsp_valid),
  .rsp_hit       (rsp_hit),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_ready (mem_rsp_ready),
  .fill_valid    (fill_valid),
  .match_vec     (match_vec)
);

// File: tb/vcb_victim_buffer_tb.sv
module vcb_victim_buffer_tb;
  localparam int AW = 28;
  localparam int LW = 128;
  localparam int NROWS = 17;
  localparam logic [1:0] K_PRIM = 2'd0, K_VICT = 2'd1, K_MEM = 2'd2;

  // Access sequence: letter index, expected serving level
  localparam logic [3:0] ROW_ADDR [NROWS] =
    '{4'd0, 4'd1, 4'd0, 4'd1, 4'd0, 4'd1, 4'd1, 4'd2, 4'd3,
      4'd4, 4'd5, 4'd0, 4'd2, 4'd6, 4'd0, 4'd3, 4'd5};
  localparam logic [1:0] ROW_KIND [NROWS] =
    '{K_MEM, K_MEM, K_VICT, K_VICT, K_VICT, K_VICT, K_PRIM, K_MEM, K_MEM,
      K_MEM, K_MEM, K_MEM, K_VICT, K_MEM, K_MEM, K_MEM, K_VICT};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          probe_valid = 1'b0;
  logic          probe_ready;
  logic [AW-1:0] probe_addr = '0;
  logic          evict_valid = 1'b0;
  logic [AW-1:0] evict_addr = '0;
  logic [LW-1:0] evict_line = '0;
  logic          rsp_valid, rsp_hit;
  logic [LW-1:0] rsp_line;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid = 1'b0;
  logic          mem_rsp_ready;
  logic [LW-1:0] mem_rsp_line = '0;
  logic          fill_valid;
  logic [LW-1:0] fill_line;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;

  // Bench model of the single conflicting primary slot
  logic          slot_v;
  logic [AW-1:0] slot_addr;
  logic [LW-1:0] slot_line;

  always #10 clk = ~clk;

  vcb_victim_buffer u_dut (
    .clk (clk), .rst_n (rst_n),
    .probe_valid (probe_valid), .probe_ready (probe_ready), .probe_addr (probe_addr),
    .evict_valid (evict_valid), .evict_addr (evict_addr), .evict_line (evict_line),
    .rsp_valid (rsp_valid), .rsp_hit (rsp_hit), .rsp_line (rsp_line),
    .mem_req_valid (mem_req_valid), .mem_req_ready (mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid), .mem_rsp_ready (mem_rsp_ready),
    .mem_rsp_line (mem_rsp_line),
    .fill_valid (fill_valid), .fill_line (fill_line)
  );

  function automatic logic [AW-1:0] addr_of(input int k);
    return 28'h0000040 | (AW'(k + 1) << 16);
  endfunction

  function automatic logic [LW-1:0] line_of(input logic [AW-1:0] a);
    return {4{a ^ 28'h5a5a5a5, 4'h3}};
  endfunction

  task automatic check(input bit ok, input string req, input logic [LW-1:0] act,
                       input logic [LW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check(probe_ready && !rsp_valid && !mem_req_valid && !fill_valid && !mem_rsp_ready,
          "R1 reset outputs",
          {probe_ready, rsp_valid, mem_req_valid, fill_valid, mem_rsp_ready}, 5'b10000);
  endtask

  // One probe, with full memory service on a miss. Returns hit and line.
  task automatic probe(input logic [AW-1:0] a, input logic ev_v, input logic [AW-1:0] ev_a,
                       input logic [LW-1:0] ev_l, input int lat,
                       output bit hit, output logic [LW-1:0] got);
    @(negedge clk);
    probe_valid = 1'b1;
    probe_addr  = a;
    evict_valid = ev_v;
    evict_addr  = ev_a;
    evict_line  = ev_l;
    @(negedge clk);
    probe_valid = 1'b0;
    check(rsp_valid, "R3 response pulse", rsp_valid, 1);
    hit = rsp_hit;
    got = rsp_line;
    if (!rsp_hit) begin
      check(mem_req_valid && mem_req_addr == a, "R5 request raised with address",
            {mem_req_valid, mem_req_addr}, {1'b1, a});
      for (int k = 0; k < lat; k++) begin
        @(negedge clk);
        check(mem_req_valid && mem_req_addr == a && !probe_ready,
              "R5 R6 request held, probes blocked",
              {mem_req_valid, mem_req_addr, probe_ready}, {1'b1, a, 1'b0});
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      check(mem_rsp_ready && !mem_req_valid && !probe_ready, "R7 waiting for data",
            {mem_rsp_ready, mem_req_valid, probe_ready}, 3'b100);
      mem_rsp_valid = 1'b1;
      mem_rsp_line  = line_of(a);
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      check(fill_valid && fill_line == line_of(a), "R7 fill data",
            fill_line, line_of(a));
      check(probe_ready, "R6 probe ready after fill", probe_ready, 1);
      got = fill_line;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin : main
    bit            h;
    logic [LW-1:0] l;
    logic [1:0]    kind;

    do_reset();
    slot_v = 1'b0; slot_addr = '0; slot_line = '0;

    // R9 R10 R11: conflicting accesses through one primary slot
    for (int r = 0; r < NROWS; r++) begin
      logic [AW-1:0] a;
      a = addr_of(int'(ROW_ADDR[r]));
      if (slot_v && slot_addr == a) begin
        kind = K_PRIM;
        l = slot_line;
      end else begin
        probe(a, slot_v, slot_addr, slot_line, r % 3, h, l);
        kind = h ? K_VICT : K_MEM;
      end
      check(kind == ROW_KIND[r], $sformatf("R2 R9 R10 R11 row %0d serving level", r),
            kind, ROW_KIND[r]);
      check(l == line_of(a), $sformatf("R3 R4 row %0d line data", r), l, line_of(a));
      slot_v = 1'b1; slot_addr = a; slot_line = l;
    end

    // R1: reset in mid-use empties the buffer (C was stored)
    do_reset();
    probe(addr_of(2), 1'b0, '0, '0, 1, h, l);
    check(!h, "R1 stored line forgotten after reset", h, 0);

    // R8: valid displaced line is inserted on fill
    probe(addr_of(9), 1'b1, addr_of(2), line_of(addr_of(2)), 0, h, l);
    check(!h, "R8 new address misses", h, 0);
    // R4: swap with an invalid displaced line empties the entry
    probe(addr_of(2), 1'b0, '0, '0, 0, h, l);
    check(h && l == line_of(addr_of(2)), "R8 inserted line found", l, line_of(addr_of(2)));
    probe(addr_of(2), 1'b0, '0, '0, 0, h, l);
    check(!h, "R4 entry emptied by invalid swap", h, 0);
    // R8: invalid displaced line inserts nothing (the previous miss had none)
    probe(28'h0000000, 1'b0, '0, '0, 0, h, l);
    check(!h, "R8 no spurious entry at zero address", h, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule